// File: doc/BRIEF.md
# Programmable Watchdog Timer with Step Multiplier

This block supervises a processor by counting down a programmable interval and raising a flag plus an interrupt request when the interval expires without being serviced. A single 8-bit configuration byte selects the interval. Its upper five bits are a multiplier and its lower three bits pick a step length. The interval is the multiplier times the step. The block counts on a single-cycle enable derived from a 32.768 kHz time base, so it can run in a fast clock domain.

Software services the watchdog by writing the configuration byte again. That write restarts the interval and drops the interrupt. A write to any timekeeping register of the surrounding clock also restarts the interval, but it leaves the interrupt alone. Reading the flags register clears the flag. Writing zero to the configuration byte turns the watchdog off. Step codes above the defined range never expire. A zero multiplier with a defined nonzero step code expires at once. After an expiry the block stays quiet until the next restart.

Top module: `wdog_timer`

## Requirements
- R1: After reset the flag and the interrupt are low and the configuration is 00h, so no expiry happens until a write arrives.
- R2: Configuration bits [7:3] hold the multiplier M and bits [2:0] hold the step code. The codes 0, 1, 2, 3 and 4 give steps of 1, 4, 16, 64 and 960 times BASE_TICKS enabled ticks. With the default BASE_TICKS of 2048 these are 1/16 s, 1/4 s, 1 s, 4 s and 1 min. Both the flag and the interrupt become visible M×step enabled ticks after the write edge.
- R3: Only cycles with the tick enable high advance the interval.
- R4: Step codes 5, 6 and 7 never cause an expiry, whatever the multiplier.
- R5: A multiplier of 0 with step code 1 to 4 raises the flag and the interrupt on the clock edge after the write.
- R6: Writing 00h clears the interrupt and disables the watchdog until a nonzero value is written.
- R7: A configuration write restarts the interval from zero and clears the interrupt. It does not clear the flag.
- R8: A clock-register write strobe restarts the interval and leaves the interrupt unchanged.
- R9: A flags-read strobe clears the flag on the next edge and does not change the interrupt. If the strobe coincides with an expiry, the flag is set.
- R10: An expiry that would land on the same edge as a restarting write is suppressed.
- R11: After an expiry, no further expiry occurs until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wd_we | input | 1 | Configuration byte write strobe |
| wd_wdata | input | 8 | Configuration byte: [7:3] multiplier, [2:0] step code |
| clk_reg_we | input | 1 | Strobe for a write to any timekeeping register |
| flags_rd | input | 1 | Strobe for a read of the flags register |
| wd_flag | output | 1 | Watchdog expiry flag |
| wd_irq | output | 1 | Watchdog interrupt request |

## Verification
Every result is registered once. The flag and the interrupt change on the edge after the internal expiry strobe. That edge is the M×step-th enabled tick after the restarting edge, or the first edge after the write when the multiplier is zero. Clears from reads and writes appear on the edge after the strobe. The bench drives strobes for exactly one cycle between falling edges. For each case it counts falling edges from the restart. It checks that the output is still low one cycle before the due edge and high right after it, so an error of one cycle either way is caught. The gated-enable case counts only enabled ticks. It places the due edge at an odd cycle offset so that counting cycles instead of ticks would fail.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  parameter int unsigned MULT_W    = 5;
  parameter int unsigned RES_W     = 3;
  parameter int unsigned CFG_W     = MULT_W + RES_W;
  parameter int unsigned RES_CODES = 1 << RES_W;
  parameter int unsigned RES_LAST  = 4;

  typedef struct packed {
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wd_cfg_t;

  // step length in units of the base step (1/16 s)
  function automatic int unsigned res_scale(int unsigned code);
    case (code)
      0:       return 1;
      1:       return 4;
      2:       return 16;
      3:       return 64;
      4:       return 960;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic             tick_en,
  input  logic [RES_W-1:0] res,
  output logic             step
);
  localparam int unsigned MAX_TICKS = res_scale(RES_LAST) * BASE_TICKS;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS);

  logic [CNT_W-1:0] len_tab [RES_CODES];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  for (genvar g = 0; g < RES_CODES; g++) begin : g_len
    if (g <= RES_LAST) begin : g_valid
      assign len_tab[g] = CNT_W'(res_scale(g) * BASE_TICKS - 1);
    end else begin : g_invalid
      assign len_tab[g] = '1;
    end
  end

  assign last_cnt = len_tab[res];
  assign step     = run && tick_en && (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= step ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_mult_cnt.sv
module wdog_mult_cnt
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              run,
  input  logic              step,
  input  logic [MULT_W-1:0] mult,
  output logic              hit
);
  logic [MULT_W-1:0] cnt_q;
  logic [MULT_W-1:0] mult_m1;
  logic              expired_q;
  logic              armed;

  assign mult_m1 = mult - MULT_W'(1);
  assign armed   = run && !clear && !expired_q;
  assign hit     = armed && ((mult == '0) || (step && (cnt_q == mult_m1)));

  always_ff @(posedge clk) begin
    if (rst || clear || !run) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else begin
      if (hit) begin
        expired_q <= 1'b1;
      end
      if (step && !expired_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic irq_clr,
  input  logic flag_clr,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (hit) begin
        flag <= 1'b1;
      end else if (flag_clr) begin
        flag <= 1'b0;
      end
      if (irq_clr) begin
        irq <= 1'b0;
      end else if (hit) begin
        irq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wd_we,
  input  logic [CFG_W-1:0] wd_wdata,
  input  logic             clk_reg_we,
  input  logic             flags_rd,
  output logic             wd_flag,
  output logic             wd_irq
);
  wd_cfg_t cfg_q;
  logic    restart;
  logic    run;
  logic    step;
  logic    timeout_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wd_we) begin
      cfg_q <= wd_cfg_t'(wd_wdata);
    end
  end

  assign restart = wd_we || clk_reg_we;
  assign run     = (cfg_q != '0) && (int'(cfg_q.res) <= int'(RES_LAST));

  wdog_prescale #(.BASE_TICKS(BASE_TICKS)) u_prescale (
    .clk     (clk),
    .rst     (rst),
    .clear   (restart),
    .run     (run),
    .tick_en (tick_en),
    .res     (cfg_q.res),
    .step    (step)
  );

  wdog_mult_cnt u_mult (
    .clk   (clk),
    .rst   (rst),
    .clear (restart),
    .run   (run),
    .step  (step),
    .mult  (cfg_q.mult),
    .hit   (timeout_hit)
  );

  wdog_status u_status (
    .clk      (clk),
    .rst      (rst),
    .hit      (timeout_hit),
    .irq_clr  (wd_we),
    .flag_clr (flags_rd),
    .flag     (wd_flag),
    .irq      (wd_irq)
  );
endmodule

// File: rtl/wdog_timer_sva.sv
module wdog_timer_sva
  import wdog_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wd_we,
  input logic [CFG_W-1:0] wd_wdata,
  input logic             clk_reg_we,
  input logic             flags_rd,
  input logic [CFG_W-1:0] cfg,
  input logic             timeout_hit,
  input logic             wd_flag,
  input logic             wd_irq
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!wd_flag && !wd_irq));

  assert_expiry_outputs_R2: assert property (@(posedge clk) disable iff (rst)
    timeout_hit |=> (wd_flag && wd_irq));

  assert_invalid_code_R4: assert property (@(posedge clk) disable iff (rst)
    (int'(cfg[RES_W-1:0]) > int'(RES_LAST)) |-> !timeout_hit);

  assert_zero_mult_R5: assert property (@(posedge clk) disable iff (rst)
    (wd_we && wd_wdata[CFG_W-1:RES_W] == '0 && wd_wdata[RES_W-1:0] != '0
     && int'(wd_wdata[RES_W-1:0]) <= int'(RES_LAST))
    |=> (timeout_hit || wd_we || clk_reg_we));

  assert_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg == '0) |-> !timeout_hit);

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
    wd_we |=> !wd_irq);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (flags_rd && !timeout_hit) |=> !wd_flag);

  assert_restart_suppress_R10: assert property (@(posedge clk) disable iff (rst)
    (wd_we || clk_reg_we) |-> !timeout_hit);
endmodule

bind wdog_timer wdog_timer_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .wd_we       (wd_we),
  .wd_wdata    (wd_wdata),
  .clk_reg_we  (clk_reg_we),
  .flags_rd    (flags_rd),
  .cfg         (cfg_q),
  .timeout_hit (timeout_hit),
  .wd_flag     (wd_flag),
  .wd_irq      (wd_irq)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  localparam int unsigned BASE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       wd_we = 1'b0;
  logic [7:0] wd_wdata = 8'h00;
  logic       clk_reg_we = 1'b0;
  logic       flags_rd = 1'b0;
  logic       wd_flag;
  logic       wd_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  wdog_timer #(.BASE_TICKS(BASE)) i_wdog_timer (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .wd_we      (wd_we),
    .wd_wdata   (wd_wdata),
    .clk_reg_we (clk_reg_we),
    .flags_rd   (flags_rd),
    .wd_flag    (wd_flag),
    .wd_irq     (wd_irq)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic write_cfg(input logic [7:0] v);
    wd_we = 1'b1; wd_wdata = v;
    @(negedge clk);
    wd_we = 1'b0;
  endtask

  task automatic pulse_clk_reg();
    clk_reg_we = 1'b1;
    @(negedge clk);
    clk_reg_we = 1'b0;
  endtask

  task automatic pulse_flags_rd();
    flags_rd = 1'b1;
    @(negedge clk);
    flags_rd = 1'b0;
  endtask

  // expect expiry exactly n cycles after the restart edge just passed
  task automatic expect_fire(input string req, input int n);
    repeat (n - 1) @(negedge clk);
    chk(req, "flag one cycle early", wd_flag, 1'b0);
    @(negedge clk);
    chk(req, "flag at due edge", wd_flag, 1'b1);
    chk(req, "irq at due edge", wd_irq, 1'b1);
  endtask

  task automatic clean_up();
    write_cfg(8'h00);
    pulse_flags_rd();
  endtask

  task automatic t_reset();
    chk("R1", "flag after reset", wd_flag, 1'b0);
    chk("R1", "irq after reset", wd_irq, 1'b0);
    repeat (300) @(negedge clk);
    chk("R1", "no expiry while unprogrammed", wd_flag | wd_irq, 1'b0);
  endtask

  task automatic t_periods();
    write_cfg({5'd3, 3'd0}); expect_fire("R2", 3 * BASE); clean_up();
    write_cfg({5'd5, 3'd1}); expect_fire("R2", 5 * 4 * BASE); clean_up();
    write_cfg({5'd2, 3'd2}); expect_fire("R2", 2 * 16 * BASE); clean_up();
    write_cfg({5'd1, 3'd3}); expect_fire("R2", 64 * BASE); clean_up();
    write_cfg({5'd1, 3'd4}); expect_fire("R2", 960 * BASE); clean_up();
  endtask

  task automatic t_gated_ticks();
    tick_en = 1'b0;
    write_cfg({5'd2, 3'd0});
    for (int j = 1; j <= 15; j++) begin
      tick_en = j[0];
      @(negedge clk);
      if (j == 14) chk("R3", "flag before 8th tick", wd_flag, 1'b0);
    end
    chk("R3", "flag on 8th enabled tick", wd_flag, 1'b1);
    tick_en = 1'b1;
    clean_up();
  endtask

  task automatic t_invalid_codes();
    write_cfg({5'd1, 3'd5});
    repeat (4000) @(negedge clk);
    chk("R4", "code 5 never expires", wd_flag | wd_irq, 1'b0);
    write_cfg({5'd0, 3'd7});
    repeat (50) @(negedge clk);
    chk("R4", "code 7 zero mult never expires", wd_flag | wd_irq, 1'b0);
    clean_up();
  endtask

  task automatic t_immediate_and_oneshot();
    write_cfg({5'd0, 3'd2});
    chk("R5", "flag before edge after write", wd_flag, 1'b0);
    @(negedge clk);
    chk("R5", "flag on edge after write", wd_flag, 1'b1);
    chk("R5", "irq on edge after write", wd_irq, 1'b1);
    pulse_flags_rd();
    chk("R9", "flag cleared by read", wd_flag, 1'b0);
    chk("R9", "irq kept by read", wd_irq, 1'b1);
    repeat (200) @(negedge clk);
    chk("R11", "no second expiry", wd_flag, 1'b0);
    clean_up();
  endtask

  task automatic t_disable();
    write_cfg({5'd2, 3'd0});
    expect_fire("R2", 2 * BASE);
    write_cfg(8'h00);
    chk("R6", "irq cleared by 00h", wd_irq, 1'b0);
    chk("R7", "flag kept by write", wd_flag, 1'b1);
    pulse_flags_rd();
    repeat (500) @(negedge clk);
    chk("R6", "disabled stays quiet", wd_flag | wd_irq, 1'b0);
  endtask

  task automatic t_service_restart();
    write_cfg({5'd4, 3'd0});
    repeat (10) @(negedge clk);
    write_cfg({5'd4, 3'd0});
    expect_fire("R7", 4 * BASE);
    clean_up();
  endtask

  task automatic t_clock_reg_restart();
    write_cfg({5'd4, 3'd0});
    repeat (10) @(negedge clk);
    pulse_clk_reg();
    expect_fire("R8", 4 * BASE);
    pulse_clk_reg();
    chk("R8", "irq kept by clock write", wd_irq, 1'b1);
    clean_up();
  endtask

  task automatic t_suppress_and_race();
    write_cfg({5'd2, 3'd0});
    repeat (2 * BASE - 1) @(negedge clk);
    write_cfg({5'd2, 3'd0});
    chk("R10", "expiry suppressed by restart", wd_flag, 1'b0);
    repeat (2 * BASE - 1) @(negedge clk);
    pulse_flags_rd();
    chk("R9", "expiry wins over read", wd_flag, 1'b1);
    clean_up();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_periods();
    t_gated_ticks();
    t_invalid_codes();
    t_immediate_and_oneshot();
    t_disable();
    t_service_restart();
    t_clock_reg_restart();
    t_suppress_and_race();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule